// File: doc/BRIEF.md
# Interrupt Vector Request and Service Tracker

This block keeps two 256-entry bit sets for a processor's interrupt front end: one marks vectors that have been requested and are waiting, the other marks vectors that the processor is currently servicing. Each set is stored as eight 32-bit words, so vector `v` sits in word `v/32` at bit `v%32`. Either set can be read one word at a time. Individual vectors can be set or cleared through dedicated strobes.

The block continuously reports the highest waiting vector and the highest in-service vector. Each comes from a registered result that follows every change to its set. It also carries out two protocol actions. An accept strobe moves the highest waiting vector into service. It does so only if that vector belongs to a strictly higher priority class (upper four vector bits) than the highest in-service vector, or if nothing is in service. An end-of-interrupt strobe retires the highest in-service vector.

Top module: `irq_vector_tracker`

## Requirements
- R1: A set strobe with vector v makes bit v%32 of word v/32 read back as 1 after the next clock edge, and leaves every other bit unchanged.
- R2: A clear strobe with vector v makes that bit read back as 0 after the next clock edge, and leaves every other bit unchanged.
- R3: When a set and a clear of the same vector, from any source, land on the same array in the same cycle, the bit ends up set.
- R4: After each clock edge, `pend_top_vec` equals the largest vector whose request bit is set.
- R5: `pend_valid` is 1 exactly when some request bit is set. When none is set, `pend_top_vec` is 0.
- R6: `svc_top_vec` and `svc_valid` follow the same rules for the in-service array.
- R7: An accept that is allowed clears the request bit of the highest pending vector and sets its in-service bit, both at the same clock edge.
- R8: An accept while no request bit is set changes neither array.
- R9: An accept is refused, and changes neither array, when the in-service array is nonempty and bits [7:4] of the highest pending vector are not greater than bits [7:4] of the highest in-service vector.
- R10: An end-of-interrupt clears the in-service bit of the highest in-service vector. When the in-service array is empty it has no effect.
- R11: While `rst_n` is low at a clock edge, both arrays, both top vectors and both valid flags become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_set_en | input | 1 | Set a request bit |
| pend_set_vec | input | 8 | Vector for pend_set_en |
| pend_clr_en | input | 1 | Clear a request bit |
| pend_clr_vec | input | 8 | Vector for pend_clr_en |
| svc_set_en | input | 1 | Set an in-service bit |
| svc_set_vec | input | 8 | Vector for svc_set_en |
| svc_clr_en | input | 1 | Clear an in-service bit |
| svc_clr_vec | input | 8 | Vector for svc_clr_en |
| accept_i | input | 1 | Move the highest pending vector into service |
| eoi_i | input | 1 | Retire the highest in-service vector |
| pend_rd_idx | input | 3 | Word index for the request array read |
| pend_rd_word | output | 32 | Selected request word |
| svc_rd_idx | input | 3 | Word index for the in-service array read |
| svc_rd_word | output | 32 | Selected in-service word |
| pend_top_vec | output | 8 | Highest pending vector |
| pend_valid | output | 1 | Some request bit is set |
| svc_top_vec | output | 8 | Highest in-service vector |
| svc_valid | output | 1 | Some in-service bit is set |

## Verification
A directed sequence places vectors in different words: 200 and 5, then 77. This shows whether the search order across words is correct or merely picks the lowest word. Vectors 0 and 255 exercise the word and bit boundaries. Vector 0 with the valid flag set distinguishes an empty array from a real vector 0. Accepts are tried with an empty request array, with a same-or-lower class (refused), and with an empty in-service array. Each of these outcomes implies a different guard. A long random phase then mixes set, clear, conflicting, accept and end-of-interrupt strobes, and compares every output against a behavioural model on every cycle.

// File: rtl/irqt_pkg.sv
// Package: default geometry of the vector tracker.
// Assumes WORD_W and WORDS are powers of two.
package irqt_pkg;
    localparam int IRQT_WORDS   = 8;
    localparam int IRQT_WORD_W  = 32;
    localparam int IRQT_CLASS_W = 4;
endpackage

// File: rtl/irqt_bitarray.sv
// Module: one vector bit array stored as packed words.
// Applies the clear mask, then the set mask (set wins), at each clock edge.
// Exposes the stored value, the next value and one selected word.
// Assumes the masks are already decoded by the caller.
module irqt_bitarray #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int ARR_W = WORDS * WORD_W,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARR_W-1:0]  clr_mask,
    input  logic [ARR_W-1:0]  set_mask,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [ARR_W-1:0]  arr_q,
    output logic [ARR_W-1:0]  arr_d
);
    // Per-word next value: clear first, then set so a set wins.
    for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
        assign arr_d[gw*WORD_W +: WORD_W] =
            (arr_q[gw*WORD_W +: WORD_W] & ~clr_mask[gw*WORD_W +: WORD_W])
            | set_mask[gw*WORD_W +: WORD_W];
    end

    // Storage register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) arr_q <= '0;
        else        arr_q <= arr_d;
    end

    // Word read port.
    assign rd_word = arr_q[rd_idx*WORD_W +: WORD_W];
endmodule

// File: rtl/irqt_msb_find.sv
// Module: finds the highest set bit of a word-organised array.
// Scans words from the top down and stops at the first nonzero one.
// Reports word index * WORD_W + bit index. An empty array reports 0, any=0.
module irqt_msb_find #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int ARR_W = WORDS * WORD_W,
    localparam int VEC_W = $clog2(ARR_W)
) (
    input  logic [ARR_W-1:0] arr,
    output logic [VEC_W-1:0] vec,
    output logic             any
);
    logic [WORDS-1:0] word_nz;

    // Nonzero flag for each word.
    for (genvar gw = 0; gw < WORDS; gw++) begin : g_nz
        assign word_nz[gw] = |arr[gw*WORD_W +: WORD_W];
    end

    // Top-down word scan, then the highest bit inside the chosen word.
    always_comb begin
        logic found;
        found = 1'b0;
        vec   = '0;
        for (int w = WORDS - 1; w >= 0; w--) begin
            if (!found && word_nz[w]) begin
                found = 1'b1;
                for (int b = 0; b < WORD_W; b++) begin
                    if (arr[w*WORD_W + b]) vec = VEC_W'(w * WORD_W + b);
                end
            end
        end
        any = found;
    end
endmodule

// File: rtl/irq_vector_tracker.sv
// Module: request / in-service vector tracker (top).
// Holds two vector arrays and registered highest-vector results.
// Performs class-gated accept and end-of-interrupt. Accept and EOI act
// on the registered top vectors of the current cycle.
// Assumes a single clock and a synchronous active-low reset.
module irq_vector_tracker #(
    parameter int WORDS   = irqt_pkg::IRQT_WORDS,
    parameter int WORD_W  = irqt_pkg::IRQT_WORD_W,
    parameter int CLASS_W = irqt_pkg::IRQT_CLASS_W,
    localparam int ARR_W  = WORDS * WORD_W,
    localparam int VEC_W  = $clog2(ARR_W),
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_set_en,
    input  logic [VEC_W-1:0]  pend_set_vec,
    input  logic              pend_clr_en,
    input  logic [VEC_W-1:0]  pend_clr_vec,
    input  logic              svc_set_en,
    input  logic [VEC_W-1:0]  svc_set_vec,
    input  logic              svc_clr_en,
    input  logic [VEC_W-1:0]  svc_clr_vec,
    input  logic              accept_i,
    input  logic              eoi_i,
    input  logic [IDX_W-1:0]  pend_rd_idx,
    output logic [WORD_W-1:0] pend_rd_word,
    input  logic [IDX_W-1:0]  svc_rd_idx,
    output logic [WORD_W-1:0] svc_rd_word,
    output logic [VEC_W-1:0]  pend_top_vec,
    output logic              pend_valid,
    output logic [VEC_W-1:0]  svc_top_vec,
    output logic              svc_valid
);
    localparam logic [ARR_W-1:0] ONE = {{(ARR_W-1){1'b0}}, 1'b1};

    logic [ARR_W-1:0] pend_arr, pend_nxt, svc_arr, svc_nxt;
    logic [ARR_W-1:0] pend_clr_m, pend_set_m, svc_clr_m, svc_set_m;
    logic [VEC_W-1:0] pend_top_d, svc_top_d;
    logic             pend_any_d, svc_any_d;
    logic             accept_fire, eoi_fire;

    // Accept gate: requests exist and the class is strictly above service.
    assign accept_fire = accept_i && pend_valid &&
        (!svc_valid ||
         (pend_top_vec[VEC_W-1 -: CLASS_W] > svc_top_vec[VEC_W-1 -: CLASS_W]));
    // EOI gate: only with something in service.
    assign eoi_fire = eoi_i && svc_valid;

    // Decode strobes into clear and set masks for both arrays.
    always_comb begin
        pend_clr_m = pend_clr_en ? (ONE << pend_clr_vec) : '0;
        pend_set_m = pend_set_en ? (ONE << pend_set_vec) : '0;
        svc_clr_m  = svc_clr_en  ? (ONE << svc_clr_vec)  : '0;
        svc_set_m  = svc_set_en  ? (ONE << svc_set_vec)  : '0;
        if (accept_fire) begin
            pend_clr_m = pend_clr_m | (ONE << pend_top_vec);
            svc_set_m  = svc_set_m  | (ONE << pend_top_vec);
        end
        if (eoi_fire) svc_clr_m = svc_clr_m | (ONE << svc_top_vec);
    end

    irqt_bitarray #(.WORDS(WORDS), .WORD_W(WORD_W)) u_pend_arr (
        .clk(clk), .rst_n(rst_n), .clr_mask(pend_clr_m), .set_mask(pend_set_m),
        .rd_idx(pend_rd_idx), .rd_word(pend_rd_word),
        .arr_q(pend_arr), .arr_d(pend_nxt)
    );

    irqt_bitarray #(.WORDS(WORDS), .WORD_W(WORD_W)) u_svc_arr (
        .clk(clk), .rst_n(rst_n), .clr_mask(svc_clr_m), .set_mask(svc_set_m),
        .rd_idx(svc_rd_idx), .rd_word(svc_rd_word),
        .arr_q(svc_arr), .arr_d(svc_nxt)
    );

    irqt_msb_find #(.WORDS(WORDS), .WORD_W(WORD_W)) u_pend_msb (
        .arr(pend_nxt), .vec(pend_top_d), .any(pend_any_d)
    );

    irqt_msb_find #(.WORDS(WORDS), .WORD_W(WORD_W)) u_svc_msb (
        .arr(svc_nxt), .vec(svc_top_d), .any(svc_any_d)
    );

    // Cached top vectors, updated at the same edge as the arrays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_top_vec <= '0;
            pend_valid   <= 1'b0;
            svc_top_vec  <= '0;
            svc_valid    <= 1'b0;
        end else begin
            pend_top_vec <= pend_top_d;
            pend_valid   <= pend_any_d;
            svc_top_vec  <= svc_top_d;
            svc_valid    <= svc_any_d;
        end
    end

    // R5
    pend_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid == (pend_arr != '0));
    // R4
    pend_top_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ((pend_arr >> pend_top_vec) == ONE));
    // R6
    svc_top_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> ((svc_arr >> svc_top_vec) == ONE));
    // R5
    pend_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (pend_top_vec == '0));
    // R7
    accept_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_fire |=> svc_arr[$past(pend_top_vec)]);
    // R8
    accept_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !pend_valid && !pend_set_en && !pend_clr_en) |=> $stable(pend_arr));
    // R10
    eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !svc_valid && !svc_set_en && !svc_clr_en && !accept_fire)
        |=> $stable(svc_arr));
endmodule

// File: tb/irq_vector_tracker_bench.sv
module irq_vector_tracker_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       ps_en = 0, pc_en = 0, ss_en = 0, sc_en = 0, acc = 0, eoi = 0;
    logic [7:0] ps_v = 0, pc_v = 0, ss_v = 0, sc_v = 0;
    logic [2:0] pri = 0, sri = 0;
    logic [31:0] pw, sw;
    logic [7:0] ptop, stop;
    logic       pval, sval;

    irq_vector_tracker u_irq_vector_tracker (
        .clk(clk), .rst_n(rst_n),
        .pend_set_en(ps_en), .pend_set_vec(ps_v),
        .pend_clr_en(pc_en), .pend_clr_vec(pc_v),
        .svc_set_en(ss_en), .svc_set_vec(ss_v),
        .svc_clr_en(sc_en), .svc_clr_vec(sc_v),
        .accept_i(acc), .eoi_i(eoi),
        .pend_rd_idx(pri), .pend_rd_word(pw),
        .svc_rd_idx(sri), .svc_rd_word(sw),
        .pend_top_vec(ptop), .pend_valid(pval),
        .svc_top_vec(stop), .svc_valid(sval)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    bit [255:0] m_pend = '0, m_svc = '0;
    string tag = "R11";

    function automatic int highest(bit [255:0] a);
        for (int i = 255; i >= 0; i--) if (a[i]) return i;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Full comparison against the model, done every cycle.
    task automatic compare();
        chk(ptop == 8'(highest(m_pend)), "R4", "pend_top_vec", 32'(ptop), 32'(highest(m_pend)));
        chk(pval == (m_pend != 0), "R5", "pend_valid", 32'(pval), 32'(m_pend != 0));
        chk(stop == 8'(highest(m_svc)), "R6", "svc_top_vec", 32'(stop), 32'(highest(m_svc)));
        chk(sval == (m_svc != 0), "R6", "svc_valid", 32'(sval), 32'(m_svc != 0));
        chk(pw == m_pend[pri*32 +: 32], tag, "pend_rd_word", pw, m_pend[pri*32 +: 32]);
        chk(sw == m_svc[sri*32 +: 32], tag, "svc_rd_word", sw, m_svc[sri*32 +: 32]);
    endtask

    // Apply current inputs for one clock, update the model, compare.
    task automatic tick();
        bit [255:0] np, ns;
        int hp, hs;
        bit ok;
        hp = highest(m_pend); hs = highest(m_svc);
        ok = acc && (m_pend != 0) && (m_svc == 0 || (hp / 16) > (hs / 16));
        np = m_pend; ns = m_svc;
        if (pc_en) np[pc_v] = 1'b0;
        if (ok) np[hp] = 1'b0;
        if (sc_en) ns[sc_v] = 1'b0;
        if (eoi && m_svc != 0) ns[hs] = 1'b0;
        if (ps_en) np[ps_v] = 1'b1;
        if (ss_en) ns[ss_v] = 1'b1;
        if (ok) ns[hp] = 1'b1;
        @(posedge clk);
        if (!rst_n) begin m_pend = '0; m_svc = '0; end
        else begin m_pend = np; m_svc = ns; end
        @(negedge clk);
        compare();
        {ps_en, pc_en, ss_en, sc_en, acc, eoi} = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        // R11: all state zero after reset
        chk(pval == 0 && ptop == 0 && sval == 0 && stop == 0, "R11", "reset outputs",
            {pval, ptop, sval, stop}, 0);
        tag = "R1";
        ps_en = 1; ps_v = 200; pri = 6; tick();
        chk(pw == 32'h100, "R1", "word6 after set 200", pw, 32'h100);
        chk(ptop == 200 && pval, "R4", "top after 200", 32'(ptop), 200);
        ps_en = 1; ps_v = 5; pri = 0; tick();
        chk(pw == 32'h20, "R1", "word0 after set 5", pw, 32'h20);
        chk(ptop == 200, "R4", "top stays 200", 32'(ptop), 200);
        tag = "R3";
        ps_en = 1; ps_v = 77; pc_en = 1; pc_v = 77; pri = 2; tick();
        chk(pw == 32'h2000, "R3", "set wins on 77", pw, 32'h2000);
        tag = "R2";
        pc_en = 1; pc_v = 200; pri = 6; tick();
        chk(pw == 0, "R2", "word6 after clear", pw, 0);
        chk(ptop == 77, "R2", "top after clear 200", 32'(ptop), 77);
        tag = "R7";
        acc = 1; pri = 2; sri = 2; tick();
        chk(pw == 0 && sw == 32'h2000, "R7", "accept 77 moves", {pw[15:0], sw[15:0]}, 32'h00002000);
        chk(stop == 77 && ptop == 5, "R7", "tops after accept", {ptop, stop}, {8'd5, 8'd77});
        tag = "R9";
        acc = 1; pri = 0; tick();
        chk(pw == 32'h20 && stop == 77, "R9", "class-blocked accept", pw, 32'h20);
        tag = "R10";
        eoi = 1; tick();
        chk(!sval && sw == 0, "R10", "eoi retires 77", sw, 0);
        eoi = 1; tick();
        chk(!sval && sw == 0, "R10", "eoi on empty", sw, 0);
        tag = "R8";
        acc = 1; sri = 0; tick();
        chk(stop == 5 && !pval, "R7", "accept into empty service", 32'(stop), 5);
        acc = 1; tick();
        chk(sw == 32'h20 && !pval, "R8", "accept with no requests", sw, 32'h20);
        tag = "R5";
        ps_en = 1; ps_v = 0; tick();
        chk(pval && ptop == 0, "R5", "vector 0 is valid", {31'd0, pval}, 1);
        ss_en = 1; ss_v = 255; sri = 7; tick();
        chk(stop == 255 && sw == 32'h80000000, "R6", "vector 255", sw, 32'h80000000);
        eoi = 1; tick();
        chk(stop == 5 && sw == 0, "R10", "eoi 255 leaves 5", 32'(stop), 5);
        // R1 R2 R3 R4 R7 R8 R9 R10: random mixed traffic
        tag = "R1";
        for (int k = 0; k < 4000; k++) begin
            int pick;
            pick = $urandom_range(0, 3);
            ps_en = ($urandom_range(0, 2) == 0); ps_v = 8'($urandom);
            pc_en = ($urandom_range(0, 2) == 0);
            pc_v = (pick == 0) ? ps_v : 8'($urandom);
            ss_en = ($urandom_range(0, 9) == 0); ss_v = 8'($urandom);
            sc_en = ($urandom_range(0, 9) == 0);
            sc_v = (pick == 1) ? ss_v : 8'($urandom);
            acc = ($urandom_range(0, 3) == 0);
            eoi = ($urandom_range(0, 4) == 0);
            pri = 3'($urandom); sri = 3'($urandom);
            if (k % 500 == 499) rst_n = 1'b0;
            tick();
            rst_n = 1'b1;
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule